// File: doc/BRIEF.md
# Byte-Wide Bus Access Sequencer

This block joins a CPU data port that issues byte or 16-bit word accesses to an internal data bus that carries only 8 bits per cycle. A request holds a 20-bit address, a read/write flag, a size flag and 16 bits of write data. The sequencer turns each request into one or two byte transfers on the narrow bus. When the request is done, it returns the assembled read data together with a done strobe that lasts one cycle.

The address decides how long each byte transfer lasts. Ordinary memory, RAM or ROM, answers in one cycle per byte. The special-function-register window at the bottom of the address space needs four cycles per byte, so the sequencer keeps the bus strobe, the address and the write byte steady for four cycles there. A word access always goes low byte first, at the even address, and then high byte at the odd address above it. A word in the register window therefore takes eight bus cycles.

Top module: `byte_bus_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, and `bus_rd` and `bus_wr` are both 0.
- R2: A byte access outside the register window drives one bus cycle, starting in the cycle after acceptance. `rsp_done` is high in the cycle after that bus cycle, so done comes 2 cycles after the accepting edge.
- R3: A word access ignores bit 0 of `req_addr`. It drives the even address with the low byte (`req_wdata[7:0]`, or read data bits 7:0) and then the odd address with the high byte (bits 15:8). A word read returns {byte at odd address, byte at even address}.
- R4: Every bus byte whose address lies in the register window, 0x00000 to 0x002FF inclusive, holds its strobe and address for exactly 4 consecutive cycles. A word there takes 8 bus cycles, and done follows in the 9th cycle.
- R5: Address 0x002FF is inside the register window and takes 4 cycles per byte. Address 0x00300 is outside and takes 1 cycle per byte.
- R6: `req_ready` is high only while no bus cycle is in progress, including the cycle in which `rsp_done` is high. A request presented while `req_ready` is low is ignored. `rsp_done` is never high for two cycles in a row.
- R7: A byte read returns the byte in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]` equal to 0. A byte write puts `req_wdata[7:0]` on `bus_wdata`.
- R8: `bus_rd` and `bus_wr` are never high together. `bus_rd` is used for reads and `bus_wr` for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_addr | input | 20 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| rsp_done | output | 1 | One-cycle pulse when the access has completed |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` on reads |
| bus_addr | output | 20 | Byte address on the narrow bus |
| bus_rd | output | 1 | Read strobe on the narrow bus |
| bus_wr | output | 1 | Write strobe on the narrow bus |
| bus_wdata | output | 8 | Write byte on the narrow bus |
| bus_rdata | input | 8 | Read byte from the narrow bus |

## Verification
The bench aims at the two edges of the register window, 0x002FF and 0x00300. A design with an off-by-one limit would give one of those bytes the wrong length, and the bench would see it as a strobe that ends early or lingers and as a done pulse at the wrong cycle. Word accesses go to odd addresses and to the top of the address space, 0xFFFFE. There a design that honoured bit 0 or swapped the lanes would put the wrong address on the bus or return the bytes reversed. The bench also presents requests while the sequencer is busy and again in the done cycle itself. A sequencer that accepted the busy-time request would show a foreign address on the bus, and one that refused the done-cycle request would start a cycle late.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 16;
    localparam int BUS_W   = 8;
    localparam int NLANES  = DATA_W / BUS_W;
    localparam int LANE_W  = (NLANES > 1) ? $clog2(NLANES) : 1;

    localparam logic [ADDR_W-1:0] DEF_SFR_LAST = 20'h002FF;
    localparam int DEF_SFR_CYC = 4;
    localparam int DEF_MEM_CYC = 1;

    typedef enum logic {
        ST_IDLE,
        ST_BEAT
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              word;
        logic              sfr;
    } seq_req_t;

    function automatic int max_cyc(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [ADDR_W-1:0] align_word(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        m = ADDR_W'(NLANES - 1);
        return a & ~m;
    endfunction

endpackage

// File: rtl/bus_seq_region.sv
module bus_seq_region
    import bus_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SFR_LAST = DEF_SFR_LAST
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_sfr
);

    always_comb begin
        in_sfr = (addr <= SFR_LAST);
    end

endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
    import bus_seq_pkg::*;
#(
    parameter int SFR_CYC = DEF_SFR_CYC,
    parameter int MEM_CYC = DEF_MEM_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_sfr,
    output logic              req_ready,
    output logic              accept,
    output logic              beat_act,
    output logic              beat_end,
    output logic [LANE_W-1:0] lane,
    output seq_req_t          cur,
    output logic              done
);

    localparam int MAXC  = max_cyc(SFR_CYC, MEM_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_e         state_q;
    seq_req_t           cur_q;
    logic [LANE_W-1:0]  lane_q;
    logic [CNT_W-1:0]   wait_q;
    logic               done_q;
    logic [LANE_W-1:0]  last_lane;
    logic               seq_end;

    function automatic logic [CNT_W-1:0] beat_len(input logic sfr);
        return sfr ? CNT_W'(SFR_CYC - 1) : CNT_W'(MEM_CYC - 1);
    endfunction

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && (state_q == ST_IDLE);
        beat_act  = (state_q == ST_BEAT);
        beat_end  = beat_act && (wait_q == '0);
        last_lane = cur_q.word ? LANE_W'(NLANES - 1) : '0;
        seq_end   = beat_end && (lane_q == last_lane);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            lane_q  <= '0;
            wait_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_q.addr  <= req_word ? align_word(req_addr) : req_addr;
                        cur_q.write <= req_write;
                        cur_q.word  <= req_word;
                        cur_q.sfr   <= req_sfr;
                        lane_q      <= '0;
                        wait_q      <= beat_len(req_sfr);
                        state_q     <= ST_BEAT;
                    end
                end
                ST_BEAT: begin
                    if (seq_end) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else if (beat_end) begin
                        lane_q <= lane_q + 1'b1;
                        wait_q <= beat_len(cur_q.sfr);
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign lane = lane_q;
    assign cur  = cur_q;
    assign done = done_q;

endmodule

// File: rtl/bus_seq_lanes.sv
module bus_seq_lanes
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANE_W-1:0] lane,
    input  logic              cap_en,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
        end else if (accept) begin
            wdata_q <= req_wdata;
        end
    end

    always_comb begin
        bus_wdata = wdata_q[lane*BUS_W +: BUS_W];
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [BUS_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= '0;
            end else if (accept) begin
                rd_q <= '0;
            end else if (cap_en && (lane == LANE_W'(g))) begin
                rd_q <= bus_rdata;
            end
        end

        assign rsp_rdata[g*BUS_W +: BUS_W] = rd_q;
    end

endmodule

// File: rtl/byte_bus_sequencer.sv
module byte_bus_sequencer
    import bus_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SFR_LAST = DEF_SFR_LAST,
    parameter int                SFR_CYC  = DEF_SFR_CYC,
    parameter int                MEM_CYC  = DEF_MEM_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata
);

    logic              req_sfr;
    logic              accept;
    logic              beat_act;
    logic              beat_end;
    logic [LANE_W-1:0] lane;
    seq_req_t          cur;
    logic              cap_en;

    bus_seq_region #(
        .SFR_LAST (SFR_LAST)
    ) u_region (
        .addr   (req_addr),
        .in_sfr (req_sfr)
    );

    bus_seq_ctrl #(
        .SFR_CYC (SFR_CYC),
        .MEM_CYC (MEM_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_word  (req_word),
        .req_sfr   (req_sfr),
        .req_ready (req_ready),
        .accept    (accept),
        .beat_act  (beat_act),
        .beat_end  (beat_end),
        .lane      (lane),
        .cur       (cur),
        .done      (rsp_done)
    );

    always_comb begin
        cap_en   = beat_end && !cur.write;
        bus_rd   = beat_act && !cur.write;
        bus_wr   = beat_act && cur.write;
        bus_addr = cur.addr | ADDR_W'(lane);
    end

    bus_seq_lanes u_lanes (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_wdata (req_wdata),
        .lane      (lane),
        .cap_en    (cap_en),
        .bus_rdata (bus_rdata),
        .bus_wdata (bus_wdata),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/bus_seq_checker.sv
module bus_seq_checker
    import bus_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SFR_LAST = DEF_SFR_LAST,
    parameter int                SFR_CYC  = DEF_SFR_CYC,
    parameter int                MEM_CYC  = DEF_MEM_CYC
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr
);

    logic              strobe;
    logic              prev_strobe_q;
    logic [ADDR_W-1:0] prev_addr_q;
    logic [7:0]        run_q;
    logic              cont;
    logic              end_run;
    logic              prev_sfr;

    always_comb begin
        strobe   = bus_rd || bus_wr;
        cont     = strobe && prev_strobe_q && (bus_addr == prev_addr_q);
        end_run  = prev_strobe_q && !cont;
        prev_sfr = (prev_addr_q <= SFR_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_strobe_q <= 1'b0;
            prev_addr_q   <= '0;
            run_q         <= '0;
        end else begin
            prev_strobe_q <= strobe;
            prev_addr_q   <= bus_addr;
            if (!strobe)   run_q <= '0;
            else if (cont) run_q <= run_q + 8'd1;
            else           run_q <= 8'd1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(bus_rd || bus_wr)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R6
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R8
    AST_ACCEPT_START: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> ((bus_rd || bus_wr) && !req_ready)); // R2
    AST_SFR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (end_run && prev_sfr) |-> (run_q == 8'(SFR_CYC))); // R4
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (end_run && !prev_sfr) |-> (run_q == 8'(MEM_CYC))); // R2
    AST_DONE_AFTER_BUS: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> prev_strobe_q); // R2

endmodule

bind byte_bus_sequencer bus_seq_checker #(
    .SFR_LAST (SFR_LAST),
    .SFR_CYC  (SFR_CYC),
    .MEM_CYC  (MEM_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr)
);

// File: tb/tb_byte_bus_sequencer.sv
`timescale 1ns/1ps
module tb_byte_bus_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [19:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;

    always #2.5 clk = ~clk;

    byte_bus_sequencer dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_addr (req_addr), .req_write (req_write),
        .req_word (req_word), .req_wdata (req_wdata),
        .req_ready (req_ready), .rsp_done (rsp_done), .rsp_rdata (rsp_rdata),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // byte-array memory, unwritten bytes read back a pattern of the address
    logic [7:0] mem [int];
    int mem_ver = 0;

    function automatic logic [7:0] peek(input logic [19:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
    endfunction

    always @(bus_addr or mem_ver) bus_rdata = peek(bus_addr);

    always @(posedge clk) begin
        if (!rst && bus_wr) begin
            mem[int'(bus_addr)] = bus_wdata;
            mem_ver = mem_ver + 1;
        end
    end

    // behavioural reference model
    int          m_left = 0;
    int          m_idx  = 0;
    int          m_per  = 1;
    logic        m_done = 1'b0;
    logic [19:0] m_addr = '0;
    logic        m_wr = 1'b0;
    logic        m_word = 1'b0;
    logic [15:0] m_wdata = '0;
    logic [15:0] m_rdata = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_left = 0; m_idx = 0; m_done = 1'b0;
        end else if (m_left > 0) begin
            m_done = (m_left == 1);
            m_left = m_left - 1;
            m_idx  = m_idx + 1;
        end else begin
            m_done = 1'b0;
            if (req_valid) begin
                m_word  = req_word;
                m_wr    = req_write;
                m_addr  = req_word ? {req_addr[19:1], 1'b0} : req_addr;
                m_wdata = req_wdata;
                m_per   = (m_addr <= 20'h002FF) ? 4 : 1;
                m_left  = m_per * (req_word ? 2 : 1);
                m_idx   = 0;
                m_rdata = req_word ? {peek(m_addr | 20'd1), peek(m_addr)}
                                   : {8'h00, peek(m_addr)};
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            int lane;
            lane = m_idx / m_per;
            chk("R6 ready", 32'(req_ready), 32'(m_left == 0));
            chk("R6 done", 32'(rsp_done), 32'(m_done));
            chk("R8 rd", 32'(bus_rd), 32'(m_left > 0 && !m_wr));
            chk("R8 wr", 32'(bus_wr), 32'(m_left > 0 && m_wr));
            if (m_left > 0) begin
                chk(m_per == 4 ? "R4 addr" : "R3 addr", 32'(bus_addr), 32'(m_addr | 20'(lane)));
                if (m_wr) chk("R7 wdata", 32'(bus_wdata), 32'(lane ? m_wdata[15:8] : m_wdata[7:0]));
            end
            if (m_done && !m_wr)
                chk(m_word ? "R3 rdata" : "R7 rdata", 32'(rsp_rdata), 32'(m_rdata));
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // issue a request at the current negedge; measure cycles to done
    task automatic do_req(input string tag, input logic [19:0] a, input logic wr,
                          input logic wd, input logic [15:0] d, input int exp_lat);
        int k;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_word = wd; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        while (!rsp_done && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " latency"}, 32'(k), 32'(exp_lat));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, sampled before any request
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 done", 32'(rsp_done), 32'd0);
        chk("R1 strobes", 32'({bus_rd, bus_wr}), 32'd0);
        @(negedge clk);

        do_req("R2 byte rd", 20'h12345, 1'b0, 1'b0, 16'h0, 2);
        do_req("R3 word rd odd", 20'h40001, 1'b0, 1'b1, 16'h0, 3);
        do_req("R7 byte wr", 20'h00310, 1'b1, 1'b0, 16'hAB5C, 2);
        do_req("R7 byte rd back", 20'h00310, 1'b0, 1'b0, 16'h0, 2);
        do_req("R4 word wr sfr", 20'h002FE, 1'b1, 1'b1, 16'hBEEF, 9);
        do_req("R4 word rd sfr", 20'h002FF, 1'b0, 1'b1, 16'h0, 9);
        do_req("R5 byte 2FF", 20'h002FF, 1'b0, 1'b0, 16'h0, 5);
        do_req("R5 byte 300", 20'h00300, 1'b0, 1'b0, 16'h0, 2);
        do_req("R4 byte 000", 20'h00000, 1'b1, 1'b0, 16'h0077, 5);
        do_req("R3 word wr top", 20'hFFFFE, 1'b1, 1'b1, 16'h1234, 3);
        do_req("R3 word rd top", 20'hFFFFF, 1'b0, 1'b1, 16'h0, 3);
        do_req("R5 word 300", 20'h00300, 1'b0, 1'b1, 16'h0, 3);

        // R6: requests while busy are ignored
        req_valid = 1'b1; req_addr = 20'h00100; req_write = 1'b0; req_word = 1'b1;
        @(negedge clk);
        req_addr = 20'h55555; req_write = 1'b1; req_word = 1'b0; req_wdata = 16'hFFFF;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        chk("R6 busy ignored", 32'(mem.exists(int'(20'h55555))), 32'd0);

        // R6: request in the done cycle starts at once
        do_req("R6 back2back a", 20'h0A000, 1'b0, 1'b0, 16'h0, 2);
        do_req("R6 back2back b", 20'h0A001, 1'b0, 1'b1, 16'h0, 3);
        @(negedge clk);
        chk("R6 idle after", 32'(req_ready), 32'd1);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule